// File: doc/BRIEF.md
# Two-Cycle Ramp Index Sequencer

This block keeps track of which half of a two-phase ramp is running, calling the halves cycle A and cycle B. It presents a single index bit that reads 0 in cycle A and 1 in cycle B. Left alone, the index flips on every timer update strobe, so the ramp alternates A, B, A, B.

Software can override the next step with a 2-bit command. The command can force the coming cycle to B, force it to A, or repeat the current cycle. The command waits until the next update strobe. On that strobe it decides the new index and then clears itself, so the default alternation resumes on the following strobe. The pending command can be read back until the strobe consumes it.

The waveform logic that uses the index sits outside this block.

Top module: `ramp_idx_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `idx_o` becomes 0 (cycle A) and `cmd_pend_o` becomes 0 (no command).
- R2: On an edge where `upd_i` is high and the pending command is 0 (no override), `idx_o` takes the inverse of its previous value.
- R3: On an edge where `upd_i` is high and the pending command is 1 (force B), `idx_o` becomes 1, whatever its previous value.
- R4: On an edge where `upd_i` is high and the pending command is 2 (force A), `idx_o` becomes 0, whatever its previous value.
- R5: On an edge where `upd_i` is high and the pending command is 3 (hold), `idx_o` keeps its previous value.
- R6: An update edge with no simultaneous non-zero write clears `cmd_pend_o` to 0.
- R7: On an edge without an update, a write (`cmd_wr_i` high) with non-zero `cmd_wdata_i` makes that value pending. It is visible on `cmd_pend_o` after that edge and replaces any earlier pending value. With no write and no update, the pending value is kept.
- R8: A write with `cmd_wdata_i` equal to 0 neither cancels nor alters the pending command.
- R9: When a non-zero write and an update land on the same edge, the previously pending command decides the index, and the written value is left pending for the next update.
- R10: On any edge without `upd_i`, `idx_o` is unchanged, whatever command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Timer update-condition strobe, one cycle per event |
| cmd_wr_i | input | 1 | Command write enable |
| cmd_wdata_i | input | 2 | Command value: 0 none, 1 force B, 2 force A, 3 hold |
| idx_o | output | 1 | Registered index: 0 = cycle A, 1 = cycle B |
| cmd_pend_o | output | 2 | Registered readback of the pending command |

## Verification
Directed phases first run bare update strobes, which show plain alternation from both index values. Each override is then applied starting from both index values, so forcing can be told apart from toggling and hold can be told apart from force. Further phases write zero over a pending command, overwrite one command with another, leave a command pending across idle cycles, and write on the same edge as a strobe, which separates the old command from the new one. A long pseudo-random phase then mixes strobes, writes and a mid-run reset, and a behavioural model checks both outputs on every clock.

// File: rtl/ramp_idx_pkg.sv
package ramp_idx_pkg;

  localparam int CMD_W = 2;

  typedef enum logic [CMD_W-1:0] {
    IDX_TOGGLE  = 2'd0,
    IDX_FORCE_B = 2'd1,
    IDX_FORCE_A = 2'd2,
    IDX_HOLD    = 2'd3
  } ridx_cmd_e;

  localparam logic IDX_CYCLE_A = 1'b0;
  localparam logic IDX_CYCLE_B = 1'b1;

endpackage

// File: rtl/ridx_cmd_slot.sv
// Holds one pending override command until an update consumes it.
module ridx_cmd_slot #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         consume_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o
);

  logic load;

  // A zero write is not a command and leaves the slot untouched.
  assign load = wr_i && (wdata_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
    end else if (load) begin
      // A new write wins over consumption: it stays queued for the next update.
      pend_o <= wdata_i;
    end else if (consume_i) begin
      pend_o <= '0;
    end
  end

endmodule

// File: rtl/ridx_next_calc.sv
// Next index value chosen from the current index and the pending command.
module ridx_next_calc
  import ramp_idx_pkg::*;
(
  input  logic      cur_i,
  input  ridx_cmd_e cmd_i,
  output logic      nxt_o
);

  always_comb begin
    unique case (cmd_i)
      IDX_FORCE_B: nxt_o = IDX_CYCLE_B;
      IDX_FORCE_A: nxt_o = IDX_CYCLE_A;
      IDX_HOLD:    nxt_o = cur_i;
      default:     nxt_o = ~cur_i;
    endcase
  end

endmodule

// File: rtl/ridx_state.sv
// Index register; it only moves on an update strobe.
module ridx_state
  import ramp_idx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic nxt_i,
  output logic idx_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= IDX_CYCLE_A;
    end else if (adv_i) begin
      idx_o <= nxt_i;
    end
  end

endmodule

// File: rtl/ramp_idx_seq.sv
module ramp_idx_seq
  import ramp_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  output logic             idx_o,
  output logic [CMD_W-1:0] cmd_pend_o
);

  logic [CMD_W-1:0] pend_q;
  logic             idx_q;
  logic             idx_nxt;

  ridx_cmd_slot #(.W(CMD_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .consume_i (upd_i),
    .wr_i      (cmd_wr_i),
    .wdata_i   (cmd_wdata_i),
    .pend_o    (pend_q)
  );

  ridx_next_calc u_calc (
    .cur_i (idx_q),
    .cmd_i (ridx_cmd_e'(pend_q)),
    .nxt_o (idx_nxt)
  );

  ridx_state u_state (
    .clk   (clk),
    .rst   (rst),
    .adv_i (upd_i),
    .nxt_i (idx_nxt),
    .idx_o (idx_q)
  );

  assign idx_o      = idx_q;
  assign cmd_pend_o = pend_q;

endmodule

// File: rtl/ramp_idx_seq_chk.sv
module ramp_idx_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_i,
  input logic       cmd_wr_i,
  input logic [1:0] cmd_wdata_i,
  input logic       idx_o,
  input logic [1:0] cmd_pend_o
);

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idx_o == 1'b0 && cmd_pend_o == 2'd0));

  // R2
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cmd_pend_o == 2'd0) |=> (idx_o != $past(idx_o)));

  // R3
  a_r3_force_b: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cmd_pend_o == 2'd1) |=> idx_o);

  // R4
  a_r4_force_a: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cmd_pend_o == 2'd2) |=> !idx_o);

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cmd_pend_o == 2'd3) |=> $stable(idx_o));

  // R6
  a_r6_consume: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !(cmd_wr_i && cmd_wdata_i != 2'd0)) |=> (cmd_pend_o == 2'd0));

  // R7
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && cmd_wr_i && cmd_wdata_i != 2'd0) |=> (cmd_pend_o == $past(cmd_wdata_i)));

  // R8
  a_r8_zero_write: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && cmd_wr_i && cmd_wdata_i == 2'd0) |=> $stable(cmd_pend_o));

  // R9
  a_r9_collide: assert property (@(posedge clk) disable iff (rst)
    (upd_i && cmd_wr_i && cmd_wdata_i != 2'd0) |=> (cmd_pend_o == $past(cmd_wdata_i)));

  // R10
  a_r10_idle_idx: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(idx_o));

endmodule

bind ramp_idx_seq ramp_idx_seq_chk u_chk (.*);

// File: tb/ramp_idx_seq_tb.sv
module ramp_idx_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_i = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [1:0] cmd_wdata_i = 2'd0;
  logic       idx_o;
  logic [1:0] cmd_pend_o;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int    m_idx = 0;
  int    m_pend = 0;
  string idx_tag = "R1";
  string pend_tag = "R1";

  always #10 clk = ~clk;   // 50 MHz

  ramp_idx_seq u_dut (
    .clk         (clk),
    .rst         (rst),
    .upd_i       (upd_i),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .idx_o       (idx_o),
    .cmd_pend_o  (cmd_pend_o)
  );

  always @(posedge clk) begin
    int old_pend;
    int wval;
    started = 1;
    wval = int'(cmd_wdata_i);
    if (rst) begin
      m_idx = 0; m_pend = 0;
      idx_tag = "R1"; pend_tag = "R1";
    end else begin
      old_pend = m_pend;
      if (upd_i) begin
        case (old_pend)
          0: begin m_idx = 1 - m_idx; idx_tag = "R2"; end
          1: begin m_idx = 1;         idx_tag = "R3"; end
          2: begin m_idx = 0;         idx_tag = "R4"; end
          default: idx_tag = "R5";
        endcase
        if (cmd_wr_i && wval != 0) begin
          m_pend = wval; pend_tag = "R9";
        end else begin
          m_pend = 0; pend_tag = "R6";
        end
      end else begin
        idx_tag = "R10";
        if (cmd_wr_i && wval != 0) begin
          m_pend = wval; pend_tag = "R7";
        end else if (cmd_wr_i) begin
          pend_tag = "R8";
        end else begin
          pend_tag = "R7";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(idx_o) != m_idx) begin
        failures++;
        $display("FAIL %s idx_o actual=%0d expected=%0d t=%0t", idx_tag, idx_o, m_idx, $time);
      end
      checks++;
      if (int'(cmd_pend_o) != m_pend) begin
        failures++;
        $display("FAIL %s cmd_pend_o actual=%0d expected=%0d t=%0t", pend_tag, cmd_pend_o, m_pend, $time);
      end
    end
  end

  task automatic step(input logic u, input logic w, input logic [1:0] d);
    @(negedge clk);
    upd_i = u; cmd_wr_i = w; cmd_wdata_i = d;
  endtask

  task automatic expect_now(input string tag, input logic ei, input logic [1:0] ep);
    @(negedge clk);
    checks++;
    if (idx_o !== ei || cmd_pend_o !== ep) begin
      failures++;
      $display("FAIL %s idx/pend actual=%0d/%0d expected=%0d/%0d", tag, idx_o, cmd_pend_o, ei, ep);
    end
    upd_i = 0; cmd_wr_i = 0; cmd_wdata_i = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step(0, 0, 0);
    step(0, 0, 0); rst = 0;
    expect_now("R1", 1'b0, 2'd0);
    // R10 idle
    step(0, 0, 0); step(0, 0, 0);
    // R2 toggle A->B->A->B
    step(1, 0, 0); expect_now("R2", 1'b1, 2'd0);
    step(1, 0, 0); expect_now("R2", 1'b0, 2'd0);
    step(1, 0, 0); expect_now("R2", 1'b1, 2'd0);
    // R3 force B from B, then from A
    step(0, 1, 2'd1); expect_now("R7", 1'b1, 2'd1);
    step(1, 0, 0);    expect_now("R3", 1'b1, 2'd0);
    step(1, 0, 0);    // toggles to A
    step(0, 1, 2'd1); step(1, 0, 0); expect_now("R3", 1'b1, 2'd0);
    // R4 force A from B, then from A
    step(0, 1, 2'd2); step(1, 0, 0); expect_now("R4", 1'b0, 2'd0);
    step(0, 1, 2'd2); step(1, 0, 0); expect_now("R4", 1'b0, 2'd0);
    // R5 hold from A, then from B
    step(0, 1, 2'd3); step(1, 0, 0); expect_now("R5", 1'b0, 2'd0);
    step(1, 0, 0);
    step(0, 1, 2'd3); step(1, 0, 0); expect_now("R5", 1'b1, 2'd0);
    // R8 zero write keeps pending
    step(0, 1, 2'd2); step(0, 1, 2'd0); expect_now("R8", 1'b1, 2'd2);
    step(1, 0, 0); expect_now("R6", 1'b0, 2'd0);
    // R7 overwrite, R10 idle while pending
    step(0, 1, 2'd2); step(0, 1, 2'd1);
    repeat (5) step(0, 0, 0);
    expect_now("R10", 1'b0, 2'd1);
    step(1, 0, 0); expect_now("R3", 1'b1, 2'd0);
    // R9 collision: force A pending, hold written on the update edge
    step(0, 1, 2'd2); step(1, 1, 2'd3); expect_now("R9", 1'b0, 2'd3);
    step(1, 0, 0); expect_now("R5", 1'b0, 2'd0);
    // R9 zero write on update edge does not survive
    step(0, 1, 2'd1); step(1, 1, 2'd0); expect_now("R6", 1'b1, 2'd0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic u, w;
      logic [1:0] d;
      u = ($urandom % 3) == 0;
      w = ($urandom % 3) == 0;
      d = 2'($urandom);
      step(u, w, d);
      if (i == 2000) begin
        step(0, 1, 2'd3);
        rst = 1;
        step(0, 0, 0);
        rst = 0;
        expect_now("R1", 1'b0, 2'd0);
      end
    end
    step(0, 0, 0);
    step(0, 0, 0);
    finish_run();
  end

endmodule